// File: doc/BRIEF.md
# Three-Class Interrupt Mask and Priority Unit

This unit drives one interrupt request line from three classes of incoming interrupt status: timer, hardware and software (write-triggered). Each class has up to 32 lines. For every class the unit holds a mask vector. Software can change that mask in three ways:

- write the whole vector at once;
- set chosen bits through a set alias;
- clear chosen bits through a clear alias.

The two aliases let one bit change without reading the mask first.

The masked status of each class appears on its own output port and can also be read over the register bus. A read-only priority word packs three things:

- for each class, the index of the lowest-numbered source that is both pending and unmasked;
- one pending flag per class;
- the request line, which is the OR of the three flags.

The register bus has a word address, a write strobe with data, and a read strobe. Read data is registered and appears one clock after the read strobe. Word map:

- Address bits [3:2] select the class: 0 is timer, 1 is hardware, 2 is software.
- Within a class, bits [1:0] select the function: 0 is the mask, 1 is the set alias, 2 is the clear alias, 3 is the masked status.
- Address 12 is the priority word.
- Addresses 13 to 15 are unmapped.

Top module: `irq_prio_unit`

## Requirements
- R1: After a synchronous reset all three masks are zero, every masked-status output is zero, `irq_out` is 0 and `rd_data` is 0, whatever the status inputs hold.
- R2: A write to a class's mask address (offset 0) replaces the whole mask, and a read of that address returns it.
- R3: A write to a class's set alias (offset 1) ORs the written data into that class's mask. Bits written as 0 keep their old value.
- R4: A write to a class's clear alias (offset 2) ANDs that class's mask with the complement of the written data.
- R5: Reads of a set alias, a clear alias or an unmapped address (13 to 15) return zero.
- R6: Each class's masked status equals its status input ANDed with its mask. It is driven on the class's active port and returned by reads of offset 3. Writes to offset 3 change no mask.
- R7: The priority word (address 12) holds the timer flag in bit 0, the hardware flag in bit 1 and the software flag in bit 2. The timer index is in bits 12:8, the hardware index in bits 20:16 and the software index in bits 28:24. All other bits read as 0.
- R8: Each index field gives the lowest-numbered source of its class that is both pending and unmasked. It reads 0 when no such source exists.
- R9: A class flag is 1 exactly when that class has at least one source that is pending and unmasked.
- R10: `irq_out` is 1 exactly when any flag is set. It follows the status and mask combinationally, with no clock delay.
- R11: Writes to the priority address change no mask.
- R12: `rd_data` takes the addressed value at the clock edge where `rd_en` is high, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_status | input | NUM_SRC | Global timer interrupt status |
| hw_status | input | NUM_SRC | Global hardware interrupt status |
| sw_status | input | NUM_SRC | Global software interrupt status |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| tmr_active | output | NUM_SRC | Timer status ANDed with timer mask |
| hw_active | output | NUM_SRC | Hardware status ANDed with hardware mask |
| sw_active | output | NUM_SRC | Software status ANDed with software mask |
| irq_out | output | 1 | Interrupt request line |

## Verification
A corrupted mask bit shows up in two places at once. It appears in the next read of the mask, and it appears on the class's active port, where it either hides a pending source or exposes a masked one. An alias that decodes to the wrong class, or that writes the whole mask instead of setting or clearing bits, shows in the mask read one access later. A wrong priority index or flag shows in the very next read of the priority word. A stuck or late request line is visible within the same cycle as the status change that should have moved it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;
    localparam int ADDR_W = 4;
    localparam int NUM_KIND = 3;
    localparam logic [ADDR_W-1:0] PRIO_ADDR = 4'hC;

    typedef enum logic [1:0] {
        KIND_TMR = 2'd0,
        KIND_HW  = 2'd1,
        KIND_SW  = 2'd2,
        KIND_NONE = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        OP_MASK = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_ACT  = 2'd3
    } op_e;

    typedef struct packed {
        logic             any;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic  in_class;
        logic  is_prio;
        kind_e kind;
        op_e   op;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.kind     = kind_e'(a[3:2]);
        d.op       = op_e'(a[1:0]);
        d.in_class = (a[3:2] != 2'd3);
        d.is_prio  = (a == PRIO_ADDR);
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_prio(input pick_t t,
                                                    input pick_t h,
                                                    input pick_t w);
        logic [DATA_W-1:0] v;
        v        = '0;
        v[0]     = t.any;
        v[1]     = h.any;
        v[2]     = w.any;
        v[12:8]  = t.idx;
        v[20:16] = h.idx;
        v[28:24] = w.idx;
        return v;
    endfunction
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_dir,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (wr_dir) begin
            mask <= wdata;
        end else if (wr_set) begin
            mask <= mask | wdata;
        end else if (wr_clr) begin
            mask <= mask & ~wdata;
        end
    end

    assign active = status & mask;

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((mask & $past(wdata)) == $past(wdata)));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((mask & $past(wdata)) == '0));

    // R3
    set_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((mask & $past(mask)) == $past(mask)));

    // R2
    hold_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_dir || wr_set || wr_clr) |=> $stable(mask));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    output pick_t              pick
);
    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.any = 1'b1;
                pick.idx = IDX_W'(i);
            end
        end
    end

    // R8
    pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pick.any |-> req[pick.idx]);

    // R8
    pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        pick.any |-> ((req & ((NUM_SRC'(1) << pick.idx) - NUM_SRC'(1))) == '0));

    // R9
    pick_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (!pick.any && pick.idx == '0));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] tmr_status,
    input  logic [NUM_SRC-1:0] hw_status,
    input  logic [NUM_SRC-1:0] sw_status,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_SRC-1:0] tmr_active,
    output logic [NUM_SRC-1:0] hw_active,
    output logic [NUM_SRC-1:0] sw_active,
    output logic               irq_out
);
    dec_t               dec;
    logic [NUM_SRC-1:0] stat_a [NUM_KIND];
    logic [NUM_SRC-1:0] mask_a [NUM_KIND];
    logic [NUM_SRC-1:0] act_a  [NUM_KIND];
    pick_t              pick_a [NUM_KIND];
    logic [DATA_W-1:0]  prio_word;
    logic [DATA_W-1:0]  rd_next;

    assign dec = decode_addr(addr);

    assign stat_a[KIND_TMR] = tmr_status;
    assign stat_a[KIND_HW]  = hw_status;
    assign stat_a[KIND_SW]  = sw_status;

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
        logic sel;
        assign sel = wr_en && dec.in_class && (dec.kind == kind_e'(k));

        irq_mask_bank #(.NUM_SRC(NUM_SRC)) i_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_dir (sel && dec.op == OP_MASK),
            .wr_set (sel && dec.op == OP_SET),
            .wr_clr (sel && dec.op == OP_CLR),
            .wdata  (wr_data[NUM_SRC-1:0]),
            .status (stat_a[k]),
            .mask   (mask_a[k]),
            .active (act_a[k])
        );

        irq_prio_pick #(.NUM_SRC(NUM_SRC)) i_pick (
            .clk  (clk),
            .rst  (rst),
            .req  (act_a[k]),
            .pick (pick_a[k])
        );
    end

    assign tmr_active = act_a[KIND_TMR];
    assign hw_active  = act_a[KIND_HW];
    assign sw_active  = act_a[KIND_SW];

    assign prio_word = pack_prio(pick_a[KIND_TMR], pick_a[KIND_HW], pick_a[KIND_SW]);
    assign irq_out   = pick_a[KIND_TMR].any | pick_a[KIND_HW].any | pick_a[KIND_SW].any;

    always_comb begin
        rd_next = '0;
        if (dec.is_prio) begin
            rd_next = prio_word;
        end else if (dec.in_class) begin
            case (dec.op)
                OP_MASK: rd_next[NUM_SRC-1:0] = mask_a[dec.kind];
                OP_ACT:  rd_next[NUM_SRC-1:0] = act_a[dec.kind];
                default: rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R10
    irq_tmr_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_active != '0) |-> irq_out);

    // R10
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ((tmr_active | hw_active | sw_active) == '0) |-> !irq_out);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R11
    prio_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.is_prio) |=> (mask_a[KIND_TMR] == $past(mask_a[KIND_TMR])
                                   && mask_a[KIND_HW] == $past(mask_a[KIND_HW])
                                   && mask_a[KIND_SW] == $past(mask_a[KIND_SW])));
endmodule

// File: tb/test_irq_prio_unit.sv
module test_irq_prio_unit;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  tmr_status, hw_status, sw_status;
    logic [3:0]    addr;
    logic          wr_en, rd_en;
    logic [31:0]   wr_data;
    logic [31:0]   rd_data;
    logic [N-1:0]  tmr_active, hw_active, sw_active;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;
    logic [N-1:0] mdl [3];
    logic [31:0]  exp_q [$];
    string        tag_q [$];
    logic         rd_seen = 1'b0;
    logic         done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_unit #(.NUM_SRC(N)) i_irq_prio_unit (
        .clk(clk), .rst(rst),
        .tmr_status(tmr_status), .hw_status(hw_status), .sw_status(sw_status),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data),
        .tmr_active(tmr_active), .hw_active(hw_active), .sw_active(sw_active),
        .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] low_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return {1'b1, 5'(i)};
        return 6'd0;
    endfunction

    function automatic logic [31:0] model_prio();
        logic [5:0] t, h, w;
        t = low_idx(tmr_status & mdl[0]);
        h = low_idx(hw_status & mdl[1]);
        w = low_idx(sw_status & mdl[2]);
        return {3'b0, w[4:0], 3'b0, h[4:0], 3'b0, t[4:0], 5'b0, w[5], h[5], t[5]};
    endfunction

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: pops expected read data when a read has completed
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R12 actual=%h expected=<none queued>", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd12) begin
            case (a[1:0])
                2'd0: mdl[a[3:2]] = d;
                2'd1: mdl[a[3:2]] = mdl[a[3:2]] | d;
                2'd2: mdl[a[3:2]] = mdl[a[3:2]] & ~d;
                default: ;
            endcase
        end
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_ports(input string tag);
        #1;
        check({tag, " tmr_active"}, tmr_active, tmr_status & mdl[0]);
        check({tag, " hw_active"},  hw_active,  hw_status & mdl[1]);
        check({tag, " sw_active"},  sw_active,  sw_status & mdl[2]);
        check({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, |model_prio()[2:0]});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) mdl[k] = '0;
        rst = 1'b1; addr = '0; wr_en = 0; rd_en = 0; wr_data = '0;
        tmr_status = '1; hw_status = '1; sw_status = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check_ports("R1");
        bus_rd(4'd0, 32'h0, "R1 tmr mask");
        bus_rd(4'd4, 32'h0, "R1 hw mask");
        bus_rd(4'd8, 32'h0, "R1 sw mask");
        bus_rd(4'd12, 32'h0, "R1 prio");

        // R2 direct mask write
        bus_wr(4'd0, 32'hF0F0_0000);
        bus_rd(4'd0, 32'hF0F0_0000, "R2 tmr mask");
        tmr_status = 32'h3030_8800;
        check_ports("R6 tmr");
        bus_rd(4'd3, 32'h3030_0000, "R6 tmr active read");

        // R3 single bit set via alias
        bus_wr(4'd5, 32'h0000_0020);
        bus_wr(4'd5, 32'h0000_0200);
        bus_rd(4'd4, 32'h0000_0220, "R3 hw mask");
        bus_rd(4'd5, 32'h0, "R5 set alias read");
        // R4 clear via alias
        bus_wr(4'd6, 32'h0000_0020);
        bus_rd(4'd4, 32'h0000_0200, "R4 hw mask");
        bus_rd(4'd6, 32'h0, "R5 clear alias read");
        bus_rd(4'd15, 32'h0, "R5 unmapped read");

        // R7 R8 R9 several pending
        bus_wr(4'd0, 32'hFFFF_FFFF);
        hw_status = 32'h0010_0200;
        sw_status = 32'h0;
        check_ports("R9");
        bus_rd(4'd12, 32'h0009_0B03, "R7 packed word");
        bus_rd(4'd12, model_prio(), "R8 prio model");

        // R11 write to priority ignored
        bus_wr(4'd12, 32'hFFFF_FFFF);
        bus_rd(4'd0, 32'hFFFF_FFFF, "R11 tmr mask");
        bus_rd(4'd4, 32'h0000_0200, "R11 hw mask");
        bus_rd(4'd8, 32'h0, "R11 sw mask");

        // R6 write to active ignored
        bus_wr(4'd7, 32'hFFFF_FFFF);
        bus_rd(4'd4, 32'h0000_0200, "R6 hw mask after active write");

        // R8 boundaries: source 0 and source 31
        bus_wr(4'd9, 32'h8000_0001);
        sw_status = 32'h8000_0001;
        bus_rd(4'd12, model_prio(), "R8 sw idx0");
        sw_status = 32'h8000_0000;
        bus_rd(4'd12, model_prio(), "R8 sw idx31");
        bus_rd(4'd11, 32'h8000_0000, "R6 sw active read");

        // R10 combinational irq
        tmr_status = '0; hw_status = '0; sw_status = '0;
        check_ports("R10 idle");
        hw_status = 32'h0000_0200;
        check_ports("R10 rise");
        bus_rd(4'd12, model_prio(), "R9 hw only");

        // R12 hold while rd_en low
        hw_status = '0;
        repeat (3) @(negedge clk);
        check("R12 hold", rd_data, 32'h0009_0002);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule